// File: doc/BRIEF.md
# DRAM Control Register with Idle Power-Down

This block holds the 32-bit control word of a memory subsystem and turns several of its bits into live control signals. A single-register bus writes the word on a write strobe, and the read data is always present. The memory transaction sequencer reports whether it is busy each cycle. From that, an idle counter lets the block gate the DRAM clock and drop CKE after eight quiet cycles. It brings both back in the same cycle that activity returns.

Other bits drive steady outputs. One bit raises a Mode Register Set request, and the request carries a 14-bit mode value from the word. Another bit holds off new transactions while earlier data cycles are still running. A cache-enable bit releases a cache-isolate output. A debug bit routes the sequencer state onto the address pins. Two read-only bits report board straps for the cache type and the system mode.

Top module: `dram_ctl_reg`

## Requirements
- R1: After reset, every read-write bit is 0, clkGateEn and ckeOut are 1, mrsReq, overlapHold and traceSel are 0, and cacheIsolate is 1.
- R2: Read bits 31:30 and 7:1 are always 0. Read bit 9 always equals strapPipeCache and read bit 8 always equals strapServer. Writes to any of these bits have no effect.
- R3: Bits 29:16 are read-write, and mrsMode always equals them.
- R4: When bit 15 is 1, clkGateEn is 0 once memActive has been 0 at eight consecutive rising edges and is still 0. Otherwise clkGateEn is 1.
- R5: When bit 14 is 1, ckeOut is 0 under the same idle condition. Otherwise ckeOut is 1.
- R6: A cycle with memActive at 1 makes clkGateEn and ckeOut 1 in that same cycle and restarts the eight-cycle count.
- R7: Writing 1 to bit 0 sets mrsReq, and bit 0 reads back as 1. Both stay 1 until a cycle with mrsAck at 1. After that edge both read 0. Writing 0 to bit 0 does not cancel a pending request.
- R8: overlapHold is 1 exactly when bit 12 is 1 and dataBusy is 1.
- R9: cacheIsolate is 1 when bit 10 is 0 and 0 when bit 10 is 1.
- R10: traceSel follows bit 13.
- R11: Bits 15:10 read back what was last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Write strobe for the control word |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data |
| strapPipeCache | input | 1 | Strap: cache is pipelined |
| strapServer | input | 1 | Strap: server configuration |
| memActive | input | 1 | Sequencer has activity this cycle |
| dataBusy | input | 1 | Data cycles of an earlier transaction in progress |
| mrsAck | input | 1 | Sequencer accepted the mode-set request |
| clkGateEn | output | 1 | DRAM clock enable (0 = suppress) |
| ckeOut | output | 1 | CKE level |
| mrsReq | output | 1 | Mode Register Set request |
| mrsMode | output | 14 | Mode value for the request |
| overlapHold | output | 1 | Hold off starting new transactions |
| cacheIsolate | output | 1 | Isolate the cache |
| traceSel | output | 1 | Route sequencer state to address pins |

## Verification
The assertions assume that the sequencer raises mrsAck only while mrsReq is high. They also assume that memActive, dataBusy and the straps are never unknown after reset. The bench raises mrsAck for a single cycle and only while a request is pending. It holds every input at a defined level from time zero, and it changes inputs only on falling edges. The idle checks drop memActive right after a falling edge. The eight-cycle window can then be counted in whole clock periods.

// File: rtl/dram_ctl_pkg.sv
package dram_ctl_pkg;
  localparam int WORD_W  = 32;
  localparam int MODE_W  = 14;
  localparam int MODE_LO = 16;
  localparam int B_CLKAUTO  = 15;
  localparam int B_CKEAUTO  = 14;
  localparam int B_TRACE    = 13;
  localparam int B_OVLDIS   = 12;
  localparam int B_PIPECACHE = 11;
  localparam int B_CACHEEN  = 10;
  localparam int B_STRAPPIPE = 9;
  localparam int B_STRAPSRV = 8;
  localparam int B_MRS      = 0;

  typedef struct packed {
    logic regWr;
    logic mrsClr;
    logic idleSat;
  } ctlStrobes_t;
endpackage

// File: rtl/dram_ctl_ctrl.sv
module dram_ctl_ctrl
  import dram_ctl_pkg::*;
#(
  parameter int IDLE_LIMIT = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        regWrEn,
  input  logic        memActive,
  input  logic        mrsAck,
  output ctlStrobes_t strobes
);
  localparam int CNT_W = $clog2(IDLE_LIMIT + 1);
  localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(IDLE_LIMIT);

  logic [CNT_W-1:0] idleCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idleCnt <= '0;
    end else if (memActive) begin
      idleCnt <= '0;
    end else if (idleCnt != LIMIT_V) begin
      idleCnt <= idleCnt + 1'b1;
    end
  end

  always_comb begin
    strobes.regWr   = regWrEn;
    strobes.mrsClr  = mrsAck;
    strobes.idleSat = (idleCnt == LIMIT_V) && !memActive;
  end
endmodule

// File: rtl/dram_ctl_dp.sv
module dram_ctl_dp
  import dram_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrobes_t       strobes,
  input  logic [WORD_W-1:0] regWrData,
  input  logic              strapPipeCache,
  input  logic              strapServer,
  input  logic              dataBusy,
  output logic [WORD_W-1:0] regRdData,
  output logic              clkGateEn,
  output logic              ckeOut,
  output logic              mrsReq,
  output logic [MODE_W-1:0] mrsMode,
  output logic              overlapHold,
  output logic              cacheIsolate,
  output logic              traceSel
);
  logic [MODE_W-1:0] modeVal;
  logic clkAuto, ckeAuto, traceEn, ovlDis, pipeCache, cacheEn, mrsBit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      modeVal   <= '0;
      clkAuto   <= 1'b0;
      ckeAuto   <= 1'b0;
      traceEn   <= 1'b0;
      ovlDis    <= 1'b0;
      pipeCache <= 1'b0;
      cacheEn   <= 1'b0;
    end else if (strobes.regWr) begin
      modeVal   <= regWrData[MODE_LO +: MODE_W];
      clkAuto   <= regWrData[B_CLKAUTO];
      ckeAuto   <= regWrData[B_CKEAUTO];
      traceEn   <= regWrData[B_TRACE];
      ovlDis    <= regWrData[B_OVLDIS];
      pipeCache <= regWrData[B_PIPECACHE];
      cacheEn   <= regWrData[B_CACHEEN];
    end
  end

  // request bit: a write of 1 sets it, an accept clears it, a write of 0 leaves it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mrsBit <= 1'b0;
    else        mrsBit <= (strobes.regWr && regWrData[B_MRS]) || (mrsBit && !strobes.mrsClr);
  end

  always_comb begin
    regRdData = '0;
    regRdData[MODE_LO +: MODE_W] = modeVal;
    regRdData[B_CLKAUTO]   = clkAuto;
    regRdData[B_CKEAUTO]   = ckeAuto;
    regRdData[B_TRACE]     = traceEn;
    regRdData[B_OVLDIS]    = ovlDis;
    regRdData[B_PIPECACHE] = pipeCache;
    regRdData[B_CACHEEN]   = cacheEn;
    regRdData[B_STRAPPIPE] = strapPipeCache;
    regRdData[B_STRAPSRV]  = strapServer;
    regRdData[B_MRS]       = mrsBit;
  end

  assign clkGateEn    = !(clkAuto && strobes.idleSat);
  assign ckeOut       = !(ckeAuto && strobes.idleSat);
  assign mrsReq       = mrsBit;
  assign mrsMode      = modeVal;
  assign overlapHold  = ovlDis && dataBusy;
  assign cacheIsolate = !cacheEn;
  assign traceSel     = traceEn;
endmodule

// File: rtl/dram_ctl_reg.sv
module dram_ctl_reg
  import dram_ctl_pkg::*;
#(
  parameter int IDLE_LIMIT = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        regWrEn,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  input  logic        strapPipeCache,
  input  logic        strapServer,
  input  logic        memActive,
  input  logic        dataBusy,
  input  logic        mrsAck,
  output logic        clkGateEn,
  output logic        ckeOut,
  output logic        mrsReq,
  output logic [13:0] mrsMode,
  output logic        overlapHold,
  output logic        cacheIsolate,
  output logic        traceSel
);
  ctlStrobes_t strobes;

  dram_ctl_ctrl #(.IDLE_LIMIT(IDLE_LIMIT)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn),
    .memActive(memActive), .mrsAck(mrsAck), .strobes(strobes)
  );

  dram_ctl_dp u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .regWrData(regWrData),
    .strapPipeCache(strapPipeCache), .strapServer(strapServer), .dataBusy(dataBusy),
    .regRdData(regRdData), .clkGateEn(clkGateEn), .ckeOut(ckeOut),
    .mrsReq(mrsReq), .mrsMode(mrsMode), .overlapHold(overlapHold),
    .cacheIsolate(cacheIsolate), .traceSel(traceSel)
  );
endmodule

// File: rtl/dram_ctl_reg_chk.sv
module dram_ctl_reg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        regWrEn,
  input logic [31:0] regWrData,
  input logic [31:0] regRdData,
  input logic        strapPipeCache,
  input logic        strapServer,
  input logic        memActive,
  input logic        dataBusy,
  input logic        mrsAck,
  input logic        clkGateEn,
  input logic        ckeOut,
  input logic        mrsReq,
  input logic [13:0] mrsMode,
  input logic        overlapHold,
  input logic        cacheIsolate,
  input logic        traceSel
);
  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    regRdData[31:30] == 2'b00 && regRdData[7:1] == 7'd0 &&
    regRdData[9] == strapPipeCache && regRdData[8] == strapServer);

  // R3
  mode_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mrsMode == regRdData[29:16]);

  // R6
  wake_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    memActive |-> clkGateEn && ckeOut);

  // R4
  clk_fall_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clkGateEn) |-> !memActive && $past(!memActive));

  // R7
  mrs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mrsReq && !mrsAck |=> mrsReq);

  // R7
  mrs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mrsReq && mrsAck && !(regWrEn && regWrData[0]) |=> !mrsReq);

  // R9
  isolate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cacheIsolate == !regRdData[10]);

  // R8
  overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overlapHold |-> dataBusy && regRdData[12]);
endmodule

bind dram_ctl_reg dram_ctl_reg_chk u_chk (.*);

// File: tb/dram_ctl_reg_test.sv
module dram_ctl_reg_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        strapPipeCache = 1'b1;
  logic        strapServer = 1'b0;
  logic        memActive = 1'b0;
  logic        dataBusy = 1'b0;
  logic        mrsAck = 1'b0;
  logic        clkGateEn, ckeOut, mrsReq, overlapHold, cacheIsolate, traceSel;
  logic [13:0] mrsMode;

  int nChecks = 0;
  int nFails = 0;

  always #5 clk = ~clk;

  dram_ctl_reg uut (.*);

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); regWrEn = 1'b1; regWrData = d;
    @(negedge clk); regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic tReset;
    chk("R1 read", regRdData, 32'h0000_0200);
    chk("R1 clk", {31'd0, clkGateEn}, 1);
    chk("R1 cke", {31'd0, ckeOut}, 1);
    chk("R1 mrs", {31'd0, mrsReq}, 0);
    chk("R1 ovl", {31'd0, overlapHold}, 0);
    chk("R1 iso", {31'd0, cacheIsolate}, 1);
    chk("R1 trace", {31'd0, traceSel}, 0);
  endtask

  task automatic tReserved;
    memActive = 1'b1;
    wr(32'hFFFF_FFFE);
    chk("R2 allones", regRdData, 32'h3FFF_FE00);
    strapPipeCache = 1'b0; strapServer = 1'b1; #1;
    chk("R2 straps", regRdData & 32'h0000_0300, 32'h0000_0100);
    chk("R11 bits", regRdData & 32'h0000_FC00, 32'h0000_FC00);
    chk("R10 trace on", {31'd0, traceSel}, 1);
    chk("R9 iso off", {31'd0, cacheIsolate}, 0);
    wr(32'h0000_0000);
    chk("R10 trace off", {31'd0, traceSel}, 0);
    chk("R9 iso on", {31'd0, cacheIsolate}, 1);
    chk("R11 cleared", regRdData & 32'h0000_FC00, 0);
  endtask

  task automatic tMode;
    wr(32'h2ABC_0000);
    chk("R3 read", regRdData[29:16], 14'h2ABC);
    chk("R3 out", {18'd0, mrsMode}, 32'h2ABC);
    wr(32'h1543_0800);
    chk("R3 out2", {18'd0, mrsMode}, 32'h1543);
    chk("R11 pipe", {31'd0, regRdData[11]}, 1);
  endtask

  task automatic tIdle(input logic clkBit);
    memActive = 1'b1;
    wr(clkBit ? 32'h0000_8000 : 32'h0000_4000);
    memActive = 1'b0;
    repeat (7) @(negedge clk);
    chk(clkBit ? "R4 seven" : "R5 seven", {31'd0, clkBit ? clkGateEn : ckeOut}, 1);
    @(negedge clk);
    chk(clkBit ? "R4 eight" : "R5 eight", {31'd0, clkBit ? clkGateEn : ckeOut}, 0);
    chk(clkBit ? "R4 other" : "R5 other", {31'd0, clkBit ? ckeOut : clkGateEn}, 1);
    // R6: wake in the same cycle, then the count restarts
    memActive = 1'b1; #1;
    chk("R6 wake", {31'd0, clkBit ? clkGateEn : ckeOut}, 1);
    @(negedge clk); memActive = 1'b0;
    repeat (7) @(negedge clk);
    chk("R6 restart", {31'd0, clkBit ? clkGateEn : ckeOut}, 1);
    @(negedge clk);
    chk("R6 regate", {31'd0, clkBit ? clkGateEn : ckeOut}, 0);
    memActive = 1'b1;
  endtask

  task automatic tNoAuto;
    wr(32'h0000_0000);
    memActive = 1'b0;
    repeat (12) @(negedge clk);
    chk("R4 disabled", {31'd0, clkGateEn}, 1);
    chk("R5 disabled", {31'd0, ckeOut}, 1);
    memActive = 1'b1;
  endtask

  task automatic tMrs;
    wr(32'h0123_0001);
    chk("R7 req", {31'd0, mrsReq}, 1);
    chk("R7 readbit", {31'd0, regRdData[0]}, 1);
    wr(32'h0123_0000);
    repeat (2) @(negedge clk);
    chk("R7 held", {31'd0, mrsReq}, 1);
    mrsAck = 1'b1;
    @(negedge clk); mrsAck = 1'b0;
    chk("R7 cleared", {31'd0, mrsReq}, 0);
    chk("R7 readzero", {31'd0, regRdData[0]}, 0);
    chk("R3 kept", {18'd0, mrsMode}, 32'h0123);
  endtask

  task automatic tOverlap;
    wr(32'h0000_1000);
    dataBusy = 1'b1; #1;
    chk("R8 hold", {31'd0, overlapHold}, 1);
    dataBusy = 1'b0; #1;
    chk("R8 nobusy", {31'd0, overlapHold}, 0);
    wr(32'h0000_0000);
    dataBusy = 1'b1; #1;
    chk("R8 disabled", {31'd0, overlapHold}, 0);
    dataBusy = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tReset;
    rst_n = 1'b1;
    tReserved;
    tMode;
    tIdle(1'b1);
    tIdle(1'b0);
    tNoAuto;
    tMrs;
    tOverlap;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule